// File: doc/BRIEF.md
# GPU Command Packet Framer

The framer sits at the front of a rasterizer. It takes a stream of 32-bit command words and cuts it into whole command packets. The top byte of the first word is the opcode. A fixed decode turns that opcode into a packet length, or marks the packet as open-ended. Open-ended packets are polylines, and they close on a sentinel vertex word.

A drawing packet is collected in an internal buffer. It is released only after its last word has arrived, and it then goes out one word at a time on a valid/ready port, with first-word and last-word tags. A packet that is only partly delivered waits in the buffer for its remaining words, however long the gap between them. While a packet is being drained, the input is stalled.

Some opcodes are not forwarded on the drawing port:
- Pixel-transfer opcodes go, as their position and size words, to a separate port that feeds a transfer engine.
- Environment opcodes are absorbed into eight shadow registers, and selected shadow bits are folded into a status word.
- Opcodes with no meaning are consumed and dropped.

Top module: `gpf_framer`

## Requirements
- R1: After synchronous reset, no output is valid and input is accepted. Shadow register i reads (0xE0+i) shifted left by 24, and the status word is 0.
- R2: Polygon opcodes 0x20–0x3F produce fixed-length packets of 1 + V + V·T + (V−1)·G words. Here V is 4 when opcode bit 3 is set and 3 otherwise, T is opcode bit 2, and G is opcode bit 4. This gives lengths of 4, 7, 5, 9, 6, 9, 8 and 12 words for the eight groups of four.
- R3: Opcode 0x02 and opcodes 0x40–0x47 produce 3-word packets. Opcodes 0x50–0x57 and 0x80 produce 4-word packets.
- R4: Rectangle opcodes 0x60–0x7F produce packets of 2 + (bit 2) + (1 if bits 4:3 are 00) words.
- R5: Flat polyline opcodes 0x48–0x4F close on the first word at index 3 or later where (word & 0xF000F000) == 0x50005000. A matching word at an index below 3 is ordinary data.
- R6: Shaded polyline opcodes 0x58–0x5F close only on a matching word at an even index of 4 or more. A match at an odd index is ordinary data.
- R7: A polyline that has not closed by the time it reaches DEPTH words is closed at exactly DEPTH words.
- R8: A packet is presented only after all its words are in. A partial packet stays held across input gaps. Input ready is low while a packet or transfer is pending. out_first marks word 0 and out_last marks the final word.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and the tags hold steady.
- R10: Opcodes 0xA0–0xDF take 3 words. They raise xfer_valid with word 1 on xfer_pos and word 2 on xfer_size, and produce nothing on the packet port. xfer_is_read is 1 exactly when opcode bits 7:5 are 110.
- R11: Opcodes 0xE0–0xE7 store the whole word in shadow register (opcode & 7) and emit nothing.
- R12: status[10:0] equals shadow register 1 bits 10:0, and status[12:11] equals shadow register 6 bits 1:0.
- R13: Any other opcode is consumed as a single word and emits nothing.
- R14: Synchronous reset discards a partly collected packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Framer accepts a word this cycle |
| in_data | input | 32 | Command word |
| out_valid | output | 1 | Packet word available |
| out_ready | input | 1 | Downstream takes the packet word |
| out_data | output | 32 | Packet word |
| out_first | output | 1 | Word is the first of its packet |
| out_last | output | 1 | Word is the last of its packet |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_ready | input | 1 | Transfer engine takes the request |
| xfer_is_read | output | 1 | Request reads pixel memory |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| shadow_sel | input | 3 | Shadow register select for reading |
| shadow_data | output | 32 | Selected shadow register |
| status | output | 13 | Folded status bits |

## Verification
Suppose the word that completes a packet is accepted at clock edge k. Then out_valid or xfer_valid is high from edge k, and each later packet word follows one cycle after the previous one is taken. Shadow and status updates become visible one edge after the environment word is accepted. The bench drives and samples on falling edges, so every result is read half a cycle after the edge that produced it. Packet contents are compared word by word against lengths and tags computed from the opcode rules.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

    localparam int WORD_W   = 32;
    localparam int SHADOW_N = 8;

    localparam logic [WORD_W-1:0] TERM_MASK = 32'hF000_F000;
    localparam logic [WORD_W-1:0] TERM_VAL  = 32'h5000_5000;

    typedef enum logic [2:0] {
        K_NOP,
        K_FIXED,
        K_PLINE_FLAT,
        K_PLINE_SHADE,
        K_ENV,
        K_XFER
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [3:0] extra;   // words after the opcode word
    } cmd_info_t;

    typedef enum logic [1:0] {
        S_COLLECT,
        S_EMIT,
        S_XFER
    } frm_state_e;

    function automatic logic is_term(input logic [WORD_W-1:0] w);
        return (w & TERM_MASK) == TERM_VAL;
    endfunction

    function automatic cmd_info_t decode_op(input logic [7:0] op);
        cmd_info_t  r;
        logic [3:0] verts;
        r.kind  = K_NOP;
        r.extra = 4'd0;
        verts   = op[3] ? 4'd4 : 4'd3;
        if (op == 8'h02) begin
            r.kind = K_FIXED; r.extra = 4'd2;
        end else if (op[7:5] == 3'b001) begin
            r.kind  = K_FIXED;
            r.extra = verts + (op[2] ? verts : 4'd0) + (op[4] ? verts - 4'd1 : 4'd0);
        end else if (op[7:3] == 5'b01000) begin
            r.kind = K_FIXED; r.extra = 4'd2;
        end else if (op[7:3] == 5'b01001) begin
            r.kind = K_PLINE_FLAT;
        end else if (op[7:3] == 5'b01010) begin
            r.kind = K_FIXED; r.extra = 4'd3;
        end else if (op[7:3] == 5'b01011) begin
            r.kind = K_PLINE_SHADE;
        end else if (op[7:5] == 3'b011) begin
            r.kind  = K_FIXED;
            r.extra = 4'd1 + {3'd0, op[2]} + ((op[4:3] == 2'b00) ? 4'd1 : 4'd0);
        end else if (op == 8'h80) begin
            r.kind = K_FIXED; r.extra = 4'd3;
        end else if (op >= 8'hA0 && op <= 8'hDF) begin
            r.kind = K_XFER; r.extra = 4'd2;
        end else if (op[7:3] == 5'b11100) begin
            r.kind = K_ENV;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpf_cmd_decode.sv
module gpf_cmd_decode
    import gpf_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_info_t  info
);
    always_comb info = decode_op(opcode);
endmodule

// File: rtl/gpf_shadow_bank.sv
module gpf_shadow_bank
    import gpf_pkg::*;
#(
    parameter int N_REGS = SHADOW_N,
    localparam int IW    = $clog2(N_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [12:0]       status
);
    logic [WORD_W-1:0] regs_q [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        localparam logic [7:0] RST_OP = 8'(224 + g);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= {RST_OP, 24'h0};
            else if (wr_en && wr_idx == IW'(g))
                regs_q[g] <= wr_data;
        end
    end

    assign rd_data = regs_q[rd_idx];
    assign status  = {regs_q[6][1:0], regs_q[1][10:0]};

    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data)); // R11
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(status)); // R12
endmodule

// File: rtl/gpf_pkt_store.sv
module gpf_pkt_store
    import gpf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/gpf_framer.sv
module gpf_framer
    import gpf_pkg::*;
#(
    parameter int DEPTH = 16,   // must hold the longest fixed packet (12)
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_first,
    output logic        out_last,
    output logic        xfer_valid,
    input  logic        xfer_ready,
    output logic        xfer_is_read,
    output logic [31:0] xfer_pos,
    output logic [31:0] xfer_size,
    input  logic [2:0]  shadow_sel,
    output logic [31:0] shadow_data,
    output logic [12:0] status
);
    frm_state_e  state_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] rd_q;
    cmd_kind_e   kind_q;
    logic [3:0]  extra_q;
    logic        xfer_rd_q;
    logic [31:0] xfer_pos_q, xfer_size_q;

    cmd_info_t   info_in;
    cmd_kind_e   cur_kind;
    logic [3:0]  cur_extra;
    logic        first, accept, absorb, store, done, env_wr;

    gpf_cmd_decode u_dec (
        .opcode (in_data[31:24]),
        .info   (info_in)
    );

    assign in_ready  = (state_q == S_COLLECT);
    assign accept    = in_ready && in_valid;
    assign first     = (cnt_q == '0);
    assign cur_kind  = first ? info_in.kind  : kind_q;
    assign cur_extra = first ? info_in.extra : extra_q;
    assign absorb    = first && (info_in.kind == K_NOP || info_in.kind == K_ENV);
    assign store     = accept && !absorb;
    assign env_wr    = accept && first && (info_in.kind == K_ENV);

    always_comb begin
        unique case (cur_kind)
            K_PLINE_FLAT:  done = (cnt_q >= CW'(3) && is_term(in_data))
                                  || cnt_q == CW'(DEPTH - 1);
            K_PLINE_SHADE: done = (cnt_q >= CW'(4) && !cnt_q[0] && is_term(in_data))
                                  || cnt_q == CW'(DEPTH - 1);
            K_FIXED, K_XFER: done = (cnt_q == CW'(cur_extra));
            default:       done = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_COLLECT;
            cnt_q       <= '0;
            rd_q        <= '0;
            kind_q      <= K_NOP;
            extra_q     <= '0;
            xfer_rd_q   <= 1'b0;
            xfer_pos_q  <= '0;
            xfer_size_q <= '0;
        end else begin
            unique case (state_q)
                S_COLLECT: if (store) begin
                    if (first) begin
                        kind_q    <= info_in.kind;
                        extra_q   <= info_in.extra;
                        xfer_rd_q <= (in_data[31:29] == 3'b110);
                    end
                    if (cnt_q == CW'(1)) xfer_pos_q <= in_data;
                    xfer_size_q <= in_data;
                    cnt_q       <= cnt_q + CW'(1);
                    if (done) begin
                        rd_q    <= '0;
                        state_q <= (cur_kind == K_XFER) ? S_XFER : S_EMIT;
                    end
                end
                S_EMIT: if (out_ready) begin
                    if (out_last) begin
                        state_q <= S_COLLECT;
                        cnt_q   <= '0;
                    end else begin
                        rd_q <= rd_q + AW'(1);
                    end
                end
                S_XFER: if (xfer_ready) begin
                    state_q <= S_COLLECT;
                    cnt_q   <= '0;
                end
                default: state_q <= S_COLLECT;
            endcase
        end
    end

    gpf_pkt_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (store),
        .wr_idx  (cnt_q[AW-1:0]),
        .wr_data (in_data),
        .rd_idx  (rd_q),
        .rd_data (out_data)
    );

    gpf_shadow_bank u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (env_wr),
        .wr_idx  (in_data[26:24]),
        .wr_data (in_data),
        .rd_idx  (shadow_sel),
        .rd_data (shadow_data),
        .status  (status)
    );

    assign out_valid    = (state_q == S_EMIT);
    assign out_first    = (rd_q == '0);
    assign out_last     = (CW'(rd_q) == cnt_q - CW'(1));
    assign xfer_valid   = (state_q == S_XFER);
    assign xfer_is_read = xfer_rd_q;
    assign xfer_pos     = xfer_pos_q;
    assign xfer_size    = xfer_size_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_first) && $stable(out_last)); // R9
    AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (out_valid || xfer_valid) |-> !in_ready); // R8
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid && in_ready); // R8
    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_pos)
                                      && $stable(xfer_size) && $stable(xfer_is_read)); // R10
    AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && xfer_valid)); // R10
    AST_PKT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R7
endmodule

// File: tb/gpf_framer_tb.sv
module gpf_framer_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [31:0] in_data;
    logic        out_valid, out_ready, out_first, out_last;
    logic [31:0] out_data;
    logic        xfer_valid, xfer_ready, xfer_is_read;
    logic [31:0] xfer_pos, xfer_size;
    logic [2:0]  shadow_sel;
    logic [31:0] shadow_data;
    logic [12:0] status;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_w [0:31];
    int exp_n;

    always #2.5 clk = ~clk;

    gpf_framer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_is_read(xfer_is_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .shadow_sel(shadow_sel), .shadow_data(shadow_data), .status(status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // queue a packet with plain payload words, record expectation
    task automatic send_plain(input logic [7:0] op, input int n);
        exp_n = n;
        for (int k = 0; k < n; k++) begin
            exp_w[k] = (k == 0) ? {op, 24'h00_0A5A} : (32'h0001_0000 + 32'(k));
            send_word(exp_w[k]);
        end
    endtask

    task automatic grab(input string req);
        int n = 0;
        int waited = 0;
        int bad = 0;
        logic [31:0] bad_act = '0, bad_exp = '0;
        bit last;
        out_ready = 1'b1;
        while (!out_valid && waited < 50) begin @(negedge clk); waited++; end
        while (out_valid && n < 32) begin
            if (out_data !== exp_w[n] || out_first !== (n == 0) || out_last !== (n == exp_n - 1)) begin
                if (bad == 0) begin bad_act = out_data; bad_exp = exp_w[n]; end
                bad++;
            end
            last = out_last;
            n++;
            @(negedge clk);
            if (last) break;
        end
        out_ready = 1'b0;
        check(bad == 0, {req, " words/tags"}, bad_act, bad_exp);
        check(n == exp_n, {req, " length"}, 32'(n), 32'(exp_n));
    endtask

    task automatic expect_idle(input string req);
        check(!out_valid && !xfer_valid && in_ready, req,
              {29'd0, out_valid, xfer_valid, in_ready}, 32'd1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        expect_idle("R1 idle after reset");
        for (int i = 0; i < 8; i++) begin
            shadow_sel = 3'(i);
            #0.1;
            check(shadow_data == {8'(224 + i), 24'h0}, "R1 shadow reset", shadow_data, {8'(224 + i), 24'h0});
        end
        check(status == 13'h0, "R1 status reset", 32'(status), 32'h0);
    endtask

    task automatic t_polygons();
        send_plain(8'h20, 4);  grab("R2 op20");
        send_plain(8'h24, 7);  grab("R2 op24");
        send_plain(8'h2C, 9);  grab("R2 op2C");
        send_plain(8'h34, 9);  grab("R2 op34");
        send_plain(8'h3C, 12); grab("R2 op3C");
    endtask

    task automatic t_lines_fill();
        send_plain(8'h02, 3); grab("R3 op02");
        send_plain(8'h43, 3); grab("R3 op43");
        send_plain(8'h50, 4); grab("R3 op50");
        send_plain(8'h80, 4); grab("R3 op80");
    endtask

    task automatic t_rects();
        send_plain(8'h60, 3); grab("R4 op60");
        send_plain(8'h64, 4); grab("R4 op64");
        send_plain(8'h68, 2); grab("R4 op68");
        send_plain(8'h7C, 3); grab("R4 op7C");
    endtask

    task automatic t_flat_polyline();
        exp_n = 5;
        exp_w[0] = 32'h4800_1234;
        exp_w[1] = 32'h0001_0001;
        exp_w[2] = 32'h5555_5555;   // matches, but index 2 is too early
        exp_w[3] = 32'h0001_0003;
        exp_w[4] = 32'h5000_5000;
        for (int k = 0; k < exp_n; k++) send_word(exp_w[k]);
        grab("R5 flat polyline");
    endtask

    task automatic t_shaded_polyline();
        exp_n = 7;
        exp_w[0] = 32'h5800_0001;
        exp_w[1] = 32'h0001_0001;
        exp_w[2] = 32'h0001_0002;
        exp_w[3] = 32'h5FFF_5FFF;   // odd index: data
        exp_w[4] = 32'h0001_0004;
        exp_w[5] = 32'h5000_5000;   // odd index: data
        exp_w[6] = 32'h5123_5456;   // even index: closes
        for (int k = 0; k < exp_n; k++) send_word(exp_w[k]);
        grab("R6 shaded polyline");
    endtask

    task automatic t_polyline_cap();
        exp_n = DEPTH;
        exp_w[0] = 32'h4A00_0000;
        for (int k = 1; k < DEPTH; k++) exp_w[k] = 32'h0002_0000 + 32'(k);
        for (int k = 0; k < DEPTH; k++) send_word(exp_w[k]);
        grab("R7 polyline cap");
        expect_idle("R7 ready after cap");
    endtask

    task automatic t_partial_and_backpressure();
        exp_n = 3;
        exp_w[0] = 32'h4000_0007;
        exp_w[1] = 32'h0003_0001;
        exp_w[2] = 32'h0003_0002;
        send_word(exp_w[0]);
        send_word(exp_w[1]);
        repeat (5) @(negedge clk);
        expect_idle("R8 partial packet held");
        send_word(exp_w[2]);
        check(out_valid && !in_ready, "R8 complete packet presented, input stalled",
              {30'd0, out_valid, in_ready}, 32'h2);
        repeat (3) @(negedge clk);
        check(out_valid && out_data == exp_w[0] && out_first, "R9 hold under backpressure",
              out_data, exp_w[0]);
        grab("R8 packet after gap");
    endtask

    task automatic t_xfer(input logic [7:0] op, input bit rd);
        send_word({op, 24'h0});
        send_word(32'h0010_0020);
        send_word(32'h0008_0004);
        check(xfer_valid && !out_valid, "R10 transfer port only",
              {30'd0, xfer_valid, out_valid}, 32'h2);
        check(xfer_pos == 32'h0010_0020 && xfer_size == 32'h0008_0004, "R10 transfer words",
              xfer_pos, 32'h0010_0020);
        check(xfer_is_read == rd, "R10 read flag", 32'(xfer_is_read), 32'(rd));
        @(negedge clk);
        check(xfer_valid, "R10 transfer held", 32'(xfer_valid), 32'h1);
        xfer_ready = 1'b1;
        @(negedge clk);
        xfer_ready = 1'b0;
        expect_idle("R10 transfer released");
    endtask

    task automatic t_env_status();
        send_word(32'hE100_0ABC);
        send_word(32'hE600_0003);
        send_word(32'hE712_3456);
        expect_idle("R11 env words emit nothing");
        shadow_sel = 3'd1; #0.1;
        check(shadow_data == 32'hE100_0ABC, "R11 shadow 1", shadow_data, 32'hE100_0ABC);
        shadow_sel = 3'd7; #0.1;
        check(shadow_data == 32'hE712_3456, "R11 shadow 7", shadow_data, 32'hE712_3456);
        check(status == 13'h1ABC, "R12 status fold", 32'(status), 32'h1ABC);
        send_word(32'hE700_0000);
        check(status == 13'h1ABC, "R12 status unaffected by shadow 7", 32'(status), 32'h1ABC);
    endtask

    task automatic t_nops();
        send_word(32'h0000_0000);
        send_word(32'h9000_0001);
        send_word(32'hFF00_0002);
        send_word(32'hE800_0003);
        expect_idle("R13 nops consumed");
        send_plain(8'h44, 3);
        grab("R13 next packet intact after nops");
    endtask

    task automatic t_reset_mid_packet();
        send_word(32'h2C00_0000);
        send_word(32'h0004_0001);
        do_reset();
        expect_idle("R14 idle after mid-packet reset");
        send_plain(8'h40, 3);
        grab("R14 partial packet discarded");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        in_valid = 1'b0; in_data = '0; out_ready = 1'b0; xfer_ready = 1'b0; shadow_sel = '0;
        do_reset();
        t_reset_state();
        t_polygons();
        t_lines_fill();
        t_rects();
        t_flat_polyline();
        t_shaded_polyline();
        t_polyline_cap();
        t_partial_and_backpressure();
        t_xfer(8'hA0, 1'b0);
        t_xfer(8'hC0, 1'b1);
        t_xfer(8'hDF, 1'b1);
        t_xfer(8'hBF, 1'b0);
        t_env_status();
        t_nops();
        t_reset_mid_packet();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule